// File: doc/BRIEF.md
# Codec Control Slot Command Handler

This block sits in an audio codec link controller and turns two control time-slot words into register accesses on an attached codec. Software first stores a data word in the slot-2 transmit register. It then writes a command word to the slot-1 transmit register. That slot-1 write is the trigger: the block latches a command and raises a request on a simple request/acknowledge codec port. The command is the access type from bit 19 of slot 1, the 7-bit codec register address from bits 18:12 of slot 1, and the 16-bit data from bits 19:4 of slot 2.

When the codec acknowledges a read, the block builds the two receive words. Slot-1 receive gets the command echoed with its read bit cleared. Slot-2 receive gets the returned 16-bit value, shifted up by four bits into the 20-bit slot position. A seven-bit flag register reports transmit-empty, receive-busy and receive-valid state per slot. Software polls it, and reading a receive register consumes that register's valid flag.

Top module: `ctl_slot_cmd`

## Requirements
- R1: After reset the flag register reads 7'h07. Its bits are bit0 slot-1 transmit empty, bit1 slot-2 transmit empty, bit2 both empty (bit0 AND bit1), bit3 slot-1 receive busy, bit4 slot-2 receive busy, bit5 slot-1 receive valid and bit6 slot-2 receive valid. At reset the receive registers read 0 and `cmd_req` is low.
- R2: A write with select 1 stores the 20-bit value in slot-2 transmit, where select 1 reads it back. The same write clears flag bit1, and with it bit2.
- R3: A write with select 0 while no request is outstanding clears flag bit0. From the next cycle it drives `cmd_req` high, with `cmd_rd` equal to bit 19 of the written word, `cmd_addr` equal to bits 18:12, and `cmd_wdata` equal to bits 19:4 of slot-2 transmit.
- R4: `cmd_req` and the command fields hold steady until `cmd_ack` is sampled high. `cmd_req` is low in the cycle after that.
- R5: Issuing a read sets flag bits 3 and 4. Both stay set until the acknowledge.
- R6: On a read acknowledge, slot-1 receive (select 2) becomes the slot-1 transmit word with bit 19 cleared. Slot-2 receive (select 3) becomes `cmd_rdata` shifted left by 4. Bits 3 and 4 clear, bits 5 and 6 set, and bit0 is set again.
- R7: On a write acknowledge, bits 0 and 1 are set again. The receive registers and bits 5 and 6 are unchanged.
- R8: A select-0 write while a request is outstanding is ignored. Slot-1 transmit keeps its value, and no further request follows the acknowledge.
- R9: A read strobe (`rd_en`) with select 2 clears bit5, and with select 3 clears bit6. A read strobe with select 4, the flag register, clears neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 slot-1 tx, 1 slot-2 tx |
| wr_data | input | 20 | Write value |
| rd_en | input | 1 | Register read strobe (side effects) |
| rd_sel | input | 3 | Read target: 0 s1 tx, 1 s2 tx, 2 s1 rx, 3 s2 rx, 4 flags |
| rd_data | output | 20 | Selected register value |
| cmd_req | output | 1 | Codec access request |
| cmd_rd | output | 1 | Access is a read |
| cmd_addr | output | 7 | Codec register address |
| cmd_wdata | output | 16 | Codec write data |
| cmd_ack | input | 1 | Codec acknowledge |
| cmd_rdata | input | 16 | Codec read data, valid with acknowledge |

## Verification
Suppose the latched command or the outstanding-request state were corrupted. The codec port would show wrong address or data fields, or a request would drop or repeat. This shows up in the very cycle after the slot-1 write, or in the cycle after the acknowledge. Faults in the receive-capture path show at the next receive-register read as a wrong echo or a wrong shift. Faults in flag bookkeeping show at the next flag read, as busy or valid bits that fail to follow the issue, acknowledge and consume events.

// File: rtl/ctl_slot_pkg.sv
package ctl_slot_pkg;
    localparam int SLOT_W   = 20;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 3;
    localparam int RW_BIT   = SLOT_W - 1;
    localparam int ADDR_LSB = RW_BIT - ADDR_W;
    localparam int DATA_LSB = SLOT_W - DATA_W;
    localparam int FLAG_W   = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_S1TX  = 3'd0,
        SEL_S2TX  = 3'd1,
        SEL_S1RX  = 3'd2,
        SEL_S2RX  = 3'd3,
        SEL_FLAGS = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } codec_cmd_t;

    typedef struct packed {
        logic s2_valid;
        logic s1_valid;
        logic s2_busy;
        logic s1_busy;
        logic both_empty;
        logic s2_empty;
        logic s1_empty;
    } slot_flags_t;

    function automatic codec_cmd_t build_cmd(input logic [SLOT_W-1:0] s1,
                                             input logic [SLOT_W-1:0] s2);
        codec_cmd_t c;
        c.rd   = s1[RW_BIT];
        c.addr = s1[RW_BIT-1:ADDR_LSB];
        c.data = s2[SLOT_W-1:DATA_LSB];
        return c;
    endfunction

    function automatic logic [SLOT_W-1:0] echo_word(input logic [SLOT_W-1:0] s1);
        logic [SLOT_W-1:0] w;
        w = s1;
        w[RW_BIT] = 1'b0;
        return w;
    endfunction
endpackage

// File: rtl/codec_port_ctrl.sv
module codec_port_ctrl
    import ctl_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  codec_cmd_t start_cmd,
    input  logic       ack,
    output logic       req,
    output codec_cmd_t cmd,
    output logic       done
);
    typedef enum logic {P_IDLE, P_WAIT} port_st_e;
    port_st_e st;

    assign req  = (st == P_WAIT);
    assign done = req && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= P_IDLE;
            cmd <= '0;
        end else begin
            case (st)
                P_IDLE: if (start) begin
                    st  <= P_WAIT;
                    cmd <= start_cmd;
                end
                P_WAIT: if (ack) st <= P_IDLE;
                default: st <= P_IDLE;
            endcase
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
    assert_cmd_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> $stable(cmd));
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !req);
endmodule

// File: rtl/slot_flag_reg.sv
module slot_flag_reg
    import ctl_slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_s1,
    input  logic        wr_s2,
    input  logic        issue_rd,
    input  logic        done,
    input  logic        done_rd,
    input  logic        take_s1rx,
    input  logic        take_s2rx,
    output slot_flags_t flags
);
    logic s1e, s2e, s1b, s2b, s1v, s2v;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1e <= 1'b1;
            s2e <= 1'b1;
            s1b <= 1'b0;
            s2b <= 1'b0;
            s1v <= 1'b0;
            s2v <= 1'b0;
        end else begin
            if (done)           s1e <= 1'b1;
            if (wr_s1)          s1e <= 1'b0;
            if (done && !done_rd) s2e <= 1'b1;
            if (wr_s2)          s2e <= 1'b0;
            if (issue_rd) begin
                s1b <= 1'b1;
                s2b <= 1'b1;
            end else if (done) begin
                s1b <= 1'b0;
                s2b <= 1'b0;
            end
            if (take_s1rx) s1v <= 1'b0;
            if (take_s2rx) s2v <= 1'b0;
            if (done_rd) begin
                s1v <= 1'b1;
                s2v <= 1'b1;
            end
        end
    end

    always_comb begin
        flags.s1_empty   = s1e;
        flags.s2_empty   = s2e;
        flags.both_empty = s1e && s2e;
        flags.s1_busy    = s1b;
        flags.s2_busy    = s2b;
        flags.s1_valid   = s1v;
        flags.s2_valid   = s2v;
    end

    assert_valid_on_reply_R6: assert property (@(posedge clk) disable iff (rst)
        done_rd |=> (s1v && s2v && !s1b && !s2b));
    assert_valid_consumed_R9: assert property (@(posedge clk) disable iff (rst)
        (take_s1rx && !done_rd) |=> !s1v);
endmodule

// File: rtl/ctl_slot_cmd.sv
module ctl_slot_cmd
    import ctl_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [SLOT_W-1:0] rd_data,
    output logic              cmd_req,
    output logic              cmd_rd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] cmd_rdata
);
    logic [SLOT_W-1:0] s1tx, s2tx, s1rx, s2rx;
    logic        wr_s1, wr_s2, done, done_rd;
    codec_cmd_t  cur_cmd;
    slot_flags_t flags;

    assign wr_s1   = wr_en && (wr_sel == SEL_S1TX) && !cmd_req;
    assign wr_s2   = wr_en && (wr_sel == SEL_S2TX);
    assign done_rd = done && cur_cmd.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1tx <= '0;
            s2tx <= '0;
            s1rx <= '0;
            s2rx <= '0;
        end else begin
            if (wr_s1) s1tx <= wr_data;
            if (wr_s2) s2tx <= wr_data;
            if (done_rd) begin
                s1rx <= echo_word(s1tx);
                s2rx <= {cmd_rdata, {DATA_LSB{1'b0}}};
            end
        end
    end

    codec_port_ctrl u_port (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_s1),
        .start_cmd (build_cmd(wr_data, s2tx)),
        .ack       (cmd_ack),
        .req       (cmd_req),
        .cmd       (cur_cmd),
        .done      (done)
    );

    slot_flag_reg u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_s1     (wr_s1),
        .wr_s2     (wr_s2),
        .issue_rd  (wr_s1 && wr_data[RW_BIT]),
        .done      (done),
        .done_rd   (done_rd),
        .take_s1rx (rd_en && (rd_sel == SEL_S1RX)),
        .take_s2rx (rd_en && (rd_sel == SEL_S2RX)),
        .flags     (flags)
    );

    assign cmd_rd    = cur_cmd.rd;
    assign cmd_addr  = cur_cmd.addr;
    assign cmd_wdata = cur_cmd.data;

    always_comb begin
        case (rd_sel)
            SEL_S1TX:  rd_data = s1tx;
            SEL_S2TX:  rd_data = s2tx;
            SEL_S1RX:  rd_data = s1rx;
            SEL_S2RX:  rd_data = s2rx;
            SEL_FLAGS: rd_data = {{(SLOT_W-FLAG_W){1'b0}}, flags};
            default:   rd_data = '0;
        endcase
    end

    assert_busy_tracks_read_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_rd) |-> (flags.s1_busy && flags.s2_busy));
    assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_S1TX && cmd_req) |=> $stable(s1tx));
    assert_echo_clear_R6: assert property (@(posedge clk) disable iff (rst)
        done_rd |=> !s1rx[RW_BIT]);
endmodule

// File: tb/tb_ctl_slot_cmd.sv
module tb_ctl_slot_cmd;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0, rd_en = 0, cmd_ack = 0;
    logic [2:0]  wr_sel = 0, rd_sel = 0;
    logic [19:0] wr_data = 0, rd_data;
    logic        cmd_req, cmd_rd;
    logic [6:0]  cmd_addr;
    logic [15:0] cmd_wdata, cmd_rdata = 0;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_slot_cmd dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .cmd_req(cmd_req), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] sel, output logic [19:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        #1;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [19:0] v);
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 0;
        #1;
    endtask

    task automatic codec_reply(input logic [15:0] d);
        @(negedge clk);
        cmd_ack = 1; cmd_rdata = d;
        @(negedge clk);
        cmd_ack = 0;
        #1;
    endtask

    task automatic t_reset;
        logic [19:0] v;
        peek(3'd4, v); check("R1 flags", v, 20'h07);
        peek(3'd2, v); check("R1 s1rx", v, 0);
        peek(3'd3, v); check("R1 s2rx", v, 0);
        check("R1 req", cmd_req, 0);
    endtask

    task automatic t_write_access;
        logic [19:0] v;
        reg_write(3'd1, 20'hABCD0);
        peek(3'd4, v); check("R2 flags", v, 20'h01);
        peek(3'd1, v); check("R2 s2tx", v, 20'hABCD0);
        reg_write(3'd0, 20'h15000);
        check("R3 req", cmd_req, 1);
        check("R3 rd", cmd_rd, 0);
        check("R3 addr", cmd_addr, 7'h15);
        check("R3 wdata", cmd_wdata, 16'hABCD);
        peek(3'd4, v); check("R3 flags", v, 20'h00);
        repeat (3) @(negedge clk);
        #1 check("R4 hold", cmd_req, 1);
        check("R4 stable", cmd_addr, 7'h15);
        codec_reply(16'hFFFF);
        check("R4 drop", cmd_req, 0);
        peek(3'd4, v); check("R7 flags", v, 20'h07);
        peek(3'd2, v); check("R7 s1rx", v, 0);
        peek(3'd3, v); check("R7 s2rx", v, 0);
    endtask

    task automatic t_read_access;
        logic [19:0] v;
        reg_write(3'd0, 20'hAA123);
        check("R3 req rd", cmd_req, 1);
        check("R3 rd bit", cmd_rd, 1);
        check("R3 rd addr", cmd_addr, 7'h2A);
        peek(3'd4, v); check("R5 busy flags", v, 20'h1A);
        reg_write(3'd0, 20'h01000);
        peek(3'd0, v); check("R8 s1tx kept", v, 20'hAA123);
        peek(3'd4, v); check("R5 busy held", v, 20'h1A);
        codec_reply(16'h5A5A);
        peek(3'd2, v); check("R6 s1rx", v, 20'h2A123);
        peek(3'd3, v); check("R6 s2rx", v, 20'h5A5A0);
        peek(3'd4, v); check("R6 flags", v, 20'h67);
        check("R8 no req", cmd_req, 0);
        repeat (2) @(negedge clk);
        #1 check("R8 still idle", cmd_req, 0);
    endtask

    task automatic t_consume;
        logic [19:0] v;
        reg_read(3'd3, v); check("R9 s2rx data", v, 20'h5A5A0);
        peek(3'd4, v); check("R9 s2 valid cleared", v, 20'h27);
        reg_read(3'd4, v); check("R9 flags read", v, 20'h27);
        peek(3'd4, v); check("R9 flags no effect", v, 20'h27);
        reg_read(3'd2, v); check("R9 s1rx data", v, 20'h2A123);
        peek(3'd4, v); check("R9 s1 valid cleared", v, 20'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_write_access();
        t_read_access();
        t_consume();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule